// File: doc/BRIEF.md
# Programmable Serial CRC Generator

This block keeps a running cyclic redundancy remainder over a serial bit stream. Software sets it up through a small byte-wide register port. It writes a generator polynomial, writes a starting value and then sets a run bit. Each single-cycle data strobe then feeds one bit into a linear feedback shift register, most significant bit of each byte first. The polynomial is written without its constant term. Its highest set bit picks the remainder width, which can be anything from 2 to 16 bits.

To collect the result, software clears the run bit and reads the shift register. That read also copies the full remainder into the seed register, so the result can be read again from there; the old seed is lost. Writing the seed loads the shift register only while the engine is stopped. A build parameter can invert every serial bit before it reaches the feedback path.

Top module: `serial_crc_engine`

## Requirements
- R1: The polynomial register holds the generator with the x^0 term dropped: bit i stands for x^(i+1), and x^0 is always present. Polynomial 16'h8810 with seed 16'hFFFF over the ASCII bytes "123456789" gives 16'h29B1. The same polynomial with seed 16'h0000 gives 16'h31C3.
- R2: The remainder width W is the index of the highest set polynomial bit plus one. A polynomial with nothing set above bit 0 runs as W = 2. After any data step, all shift register bits at or above W read as zero.
- R3: A write to either seed byte while stopped stores the byte in the seed register. At the same edge it loads the shift register with the whole updated seed value.
- R4: A write to either seed byte while started updates the seed register and leaves the shift register unchanged.
- R5: A read of address 0 or 1 with no write in the same cycle copies the whole shift register into the seed register at that edge. A later read of the seed addresses returns the result.
- R6: While the run bit is clear, data strobes have no effect on the shift register.
- R7: While started, each strobe steps the register once. With fb = shift[W-1] XOR bit, the register moves left by one and is cut to W bits. When fb is 1 it is XORed with {poly[W-2:0],1}. Bits are taken most significant bit first.
- R8: Reset clears the shift, polynomial, seed and run registers to zero.
- R9: With INVERT_DATA = 1, every serial bit is complemented before it enters the feedback path.
- R10: Register map, low byte at the even address: 0/1 shift (read-only), 2/3 polynomial, 4/5 seed, 6 control. In the control register bit 0 is the run bit, and the other bits read as zero. Address 7 reads as zero, and writes to it or to the shift addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data byte |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| data_valid | input | 1 | One-cycle strobe carrying one serial bit |
| data_in | input | 1 | Serial data bit |

## Verification
The bench builds two copies of the engine with the same inputs: one with INVERT_DATA = 0 and one with INVERT_DATA = 1. This lets one stimulus stream check both the plain and the inverted feedback input. Both copies use the default 8-bit port and 3-bit address. Polynomials of 2, 3, 8, 11 and 16 bits exercise width selection, and two known 16-bit check values pin down the encoding of the polynomial.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_MAX_W = 16;
  typedef logic [CRC_MAX_W-1:0] crc_word_t;

  // Remainder width picked by the highest set polynomial bit (minimum 2).
  function automatic int crc_width(crc_word_t poly);
    int w;
    w = 2;
    for (int i = 1; i < CRC_MAX_W; i++) begin
      if (poly[i]) w = i + 1;
    end
    return w;
  endfunction

  function automatic crc_word_t crc_mask(int w);
    crc_word_t m;
    m = '0;
    for (int i = 0; i < CRC_MAX_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // One serial step of the feedback register.
  function automatic crc_word_t crc_step(crc_word_t st, crc_word_t poly, logic bit_in);
    int        w;
    crc_word_t m;
    crc_word_t nx;
    logic      fb;
    w  = crc_width(poly);
    m  = crc_mask(w);
    fb = st[w-1] ^ bit_in;
    nx = (st << 1) & m;
    if (fb) nx = nx ^ ({poly[CRC_MAX_W-2:0], 1'b1} & m);
    return nx;
  endfunction
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BYTES-1:0] poly_we,
  input  logic [NUM_BYTES-1:0] seed_we,
  input  logic                 ctrl_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 snap,
  input  crc_word_t            snap_val,
  output crc_word_t            poly_q,
  output crc_word_t            seed_q,
  output crc_word_t            seed_next,
  output logic                 run_q
);
  crc_word_t poly_next;

  always_comb begin
    poly_next = poly_q;
    seed_next = seed_q;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (poly_we[b]) poly_next[b*DATA_W +: DATA_W] = wdata;
      if (seed_we[b]) seed_next[b*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poly_q <= '0;
      seed_q <= '0;
      run_q  <= 1'b0;
    end else begin
      poly_q <= poly_next;
      if (|seed_we)  seed_q <= seed_next;
      else if (snap) seed_q <= snap_val;
      if (ctrl_we)   run_q  <= wdata[0];
    end
  end
endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  crc_word_t load_val,
  input  logic      step,
  input  logic      bit_in,
  input  crc_word_t poly,
  output crc_word_t shift_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    shift_q <= '0;
    else if (load) shift_q <= load_val;
    else if (step) shift_q <= crc_step(shift_q, poly, bit_in);
  end
endmodule

// File: rtl/crc_read_mux.sv
module crc_read_mux
  import crc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 3,
  parameter int SHIFT_BASE = 0,
  parameter int POLY_BASE  = 2,
  parameter int SEED_BASE  = 4,
  parameter int CTRL_ADDR  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  crc_word_t         shift_q,
  input  crc_word_t         poly_q,
  input  crc_word_t         seed_q,
  input  logic              run_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr == ADDR_W'(SHIFT_BASE + b)) rdata = shift_q[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(POLY_BASE + b))  rdata = poly_q[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(SEED_BASE + b))  rdata = seed_q[b*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(CTRL_ADDR)) rdata = {{(DATA_W-1){1'b0}}, run_q};
  end
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine
  import crc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter bit INVERT_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              data_valid,
  input  logic              data_in
);
  localparam int NUM_BYTES  = CRC_MAX_W / DATA_W;
  localparam int SHIFT_BASE = 0;
  localparam int POLY_BASE  = SHIFT_BASE + NUM_BYTES;
  localparam int SEED_BASE  = POLY_BASE + NUM_BYTES;
  localparam int CTRL_ADDR  = SEED_BASE + NUM_BYTES;

  logic [NUM_BYTES-1:0] poly_we, seed_we, shift_rd_b;
  logic      ctrl_we;
  logic      run_q;
  crc_word_t poly_q, seed_q, seed_next, shift_q;

  // Named internal events.
  logic step_fire, seed_load, seed_wr_any, shift_snap, bit_eff;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_dec
    assign poly_we[b]    = reg_wr && (reg_addr == ADDR_W'(POLY_BASE + b));
    assign seed_we[b]    = reg_wr && (reg_addr == ADDR_W'(SEED_BASE + b));
    assign shift_rd_b[b] = reg_addr == ADDR_W'(SHIFT_BASE + b);
  end
  assign ctrl_we = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

  if (INVERT_DATA) begin : g_inv
    assign bit_eff = ~data_in;
  end else begin : g_pass
    assign bit_eff = data_in;
  end

  assign seed_wr_any = |seed_we;
  assign seed_load   = seed_wr_any && !run_q;
  assign step_fire   = data_valid && run_q;
  assign shift_snap  = reg_rd && !reg_wr && (|shift_rd_b);

  crc_cfg_regs #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .poly_we(poly_we), .seed_we(seed_we), .ctrl_we(ctrl_we), .wdata(reg_wdata),
    .snap(shift_snap), .snap_val(shift_q),
    .poly_q(poly_q), .seed_q(seed_q), .seed_next(seed_next), .run_q(run_q)
  );

  crc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .load(seed_load), .load_val(seed_next),
    .step(step_fire), .bit_in(bit_eff), .poly(poly_q),
    .shift_q(shift_q)
  );

  crc_read_mux #(
    .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W),
    .SHIFT_BASE(SHIFT_BASE), .POLY_BASE(POLY_BASE),
    .SEED_BASE(SEED_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_rmux (
    .addr(reg_addr), .shift_q(shift_q), .poly_q(poly_q),
    .seed_q(seed_q), .run_q(run_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker
  import crc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      step_fire,
  input logic      seed_load,
  input logic      seed_wr_any,
  input logic      shift_snap,
  input logic      run_q,
  input crc_word_t shift_q,
  input crc_word_t seed_q,
  input crc_word_t poly_q
);
  a_r3_seed_loads_shift: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> shift_q == seed_q);

  a_r4_started_seed_keeps_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_wr_any && run_q && !step_fire) |=> $stable(shift_q));

  a_r5_snapshot_to_seed: assert property (@(posedge clk) disable iff (!rst_n)
    shift_snap |=> seed_q == $past(shift_q));

  a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !seed_load) |=> $stable(shift_q));

  a_r2_width_confined: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (shift_q & ~crc_mask(crc_width($past(poly_q)))) == '0);
endmodule

bind serial_crc_engine crc_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .step_fire(step_fire), .seed_load(seed_load),
  .seed_wr_any(seed_wr_any), .shift_snap(shift_snap), .run_q(run_q),
  .shift_q(shift_q), .seed_q(seed_q), .poly_q(poly_q)
);

// File: tb/serial_crc_engine_tb_top.sv
`timescale 1ns/1ps
module serial_crc_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rdata_p, rdata_i;
  logic       data_valid = 1'b0, data_in = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_crc_engine #(.INVERT_DATA(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_p), .data_valid(data_valid), .data_in(data_in));
  serial_crc_engine #(.INVERT_DATA(1'b1)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_i), .data_valid(data_valid), .data_in(data_in));

  typedef struct packed {
    logic [15:0] poly;
    logic [15:0] seed;
    logic [31:0] data;
    logic [5:0]  nbits;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h8810, 16'hFFFF, 32'h3132_3334, 6'd32},
    '{16'hC002, 16'h0000, 32'hDEAD_BEEF, 6'd32},
    '{16'h0005, 16'h0007, 32'h0000_00A5, 6'd8},
    '{16'h0003, 16'h0001, 32'h0000_3C5A, 6'd16},
    '{16'h0080, 16'h00FF, 32'h1234_5678, 6'd24},
    '{16'h0400, 16'h07FF, 32'h00FF_00FF, 6'd32},
    '{16'h8810, 16'h1D0F, 32'h0000_0000, 6'd0}
  };

  // Integer reference: full generator = (poly*2+1), its top term removed.
  function automatic int ref_width(int poly);
    int n = 2;
    for (int i = 15; i >= 1; i--) if ((poly >> i) & 1) begin n = i + 1; break; end
    return n;
  endfunction

  function automatic int ref_crc(int poly, int seed, int data, int nbits, int inv);
    int n    = ref_width(poly);
    int top  = 1 << n;
    int gen  = ((poly * 2) + 1) % top;
    int r    = seed;
    for (int k = nbits - 1; k >= 0; k--) begin
      int b   = ((data >> k) & 1) ^ inv;
      int msb = (r / (top / 2)) % 2;
      r = (r * 2) % top;
      if ((msb ^ b) == 1) r = r ^ gen;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] dp, output logic [7:0] di);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1; dp = rdata_p; di = rdata_i;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] vp, output logic [15:0] vi);
    logic [7:0] lp, li, hp, hi;
    rd(lo, lp, li);
    rd(lo + 3'd1, hp, hi);
    vp = {hp, lp}; vi = {hi, li};
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); data_valid = 1'b1; data_in = b;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic setup(input logic [15:0] poly, input logic [15:0] seed);
    wr(3'd6, 8'h00);
    wr(3'd2, poly[7:0]); wr(3'd3, poly[15:8]);
    wr(3'd4, seed[7:0]); wr(3'd5, seed[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] vp, vi, sp, si;
    logic [7:0]  bp, bi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, non-snapshot addresses first
    rd16(3'd2, vp, vi); chk("R8 poly", vp, 16'h0);
    rd16(3'd4, vp, vi); chk("R8 seed", vp, 16'h0);
    rd(3'd6, bp, bi);   chk("R8 run", {8'h0, bp}, 16'h0);
    rd16(3'd0, vp, vi); chk("R8 shift", vp, 16'h0);

    // R7/R9/R2/R5: table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      int   w = ref_width(int'(t.poly));
      setup(t.poly, t.seed);
      wr(3'd6, 8'h01);
      for (int k = int'(t.nbits) - 1; k >= 0; k--) send_bit(t.data[k]);
      wr(3'd6, 8'h00);
      rd16(3'd0, vp, vi);
      chk($sformatf("R7 vec%0d", v), vp, 16'(ref_crc(int'(t.poly), int'(t.seed), int'(t.data), int'(t.nbits), 0)));
      chk($sformatf("R9 vec%0d", v), vi, 16'(ref_crc(int'(t.poly), int'(t.seed), int'(t.data), int'(t.nbits), 1)));
      if (t.nbits != 0) chk($sformatf("R2 vec%0d", v), vp >> w, 16'h0);
      rd16(3'd4, sp, si);
      chk($sformatf("R5 vec%0d", v), sp, vp);
    end

    // R1: known 16-bit check values over "123456789"
    setup(16'h8810, 16'hFFFF); wr(3'd6, 8'h01);
    for (int i = 1; i <= 9; i++) send_byte(8'(8'h30 + i));
    wr(3'd6, 8'h00); rd16(3'd0, vp, vi); chk("R1 ccitt ffff", vp, 16'h29B1);
    setup(16'h8810, 16'h0000); wr(3'd6, 8'h01);
    for (int i = 1; i <= 9; i++) send_byte(8'(8'h30 + i));
    wr(3'd6, 8'h00); rd16(3'd0, vp, vi); chk("R1 ccitt 0000", vp, 16'h31C3);

    // R3 and R6: seed load while stopped, strobes ignored while stopped
    setup(16'h8810, 16'hABCD);
    rd16(3'd0, vp, vi); chk("R3 seed into shift", vp, 16'hABCD);
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    rd16(3'd0, vp, vi); chk("R6 strobes ignored", vp, 16'hABCD);

    // R10: shift read-only, address 7 inert, control upper bits
    wr(3'd0, 8'h55); wr(3'd1, 8'h66); wr(3'd7, 8'h77);
    rd16(3'd0, vp, vi); chk("R10 shift read-only", vp, 16'hABCD);
    rd(3'd7, bp, bi);   chk("R10 addr7 zero", {8'h0, bp}, 16'h0);
    wr(3'd6, 8'hFE);
    rd(3'd6, bp, bi);   chk("R10 ctrl bit0 only", {8'h0, bp}, 16'h0);
    send_bit(1'b1); send_bit(1'b0);
    rd16(3'd0, vp, vi); chk("R10 run clear", vp, 16'hABCD);

    // R4: seed write while started
    setup(16'h8810, 16'h1111);
    wr(3'd6, 8'h01);
    wr(3'd4, 8'h22); wr(3'd5, 8'h33);
    rd16(3'd4, sp, si); chk("R4 seed updated", sp, 16'h3322);
    rd16(3'd0, vp, vi); chk("R4 shift kept", vp, 16'h1111);

    // R5: snapshot overwrites the seed after steps
    wr(3'd6, 8'h00); setup(16'h8810, 16'h1234);
    wr(3'd6, 8'h01); send_byte(8'hC3); wr(3'd6, 8'h00);
    rd16(3'd4, sp, si); chk("R5 seed before read", sp, 16'h1234);
    rd16(3'd0, vp, vi);
    chk("R5 shift value", vp, 16'(ref_crc(16'h8810, 16'h1234, 8'hC3, 8, 0)));
    rd16(3'd4, sp, si); chk("R5 seed after read", sp, vp);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule